// File: doc/BRIEF.md
# Vector Element Load/Store Lane Steering

This block moves one element between a 128-bit vector register image and a 32-bit memory data word, for vector instructions that load or store a single byte, halfword or word. The caller presents the low four effective-address bits, the element size, an endian mode flag, a load/store select, the current register contents and the memory read data, all qualified by a valid strobe. One clock later the block returns either the merged register value for a load, or the memory write data and byte enables for a store.

The element index is the byte offset divided by the element size. In big-endian mode the element goes to the lane with that index and keeps its byte order. In little-endian mode the lane index is mirrored to (lanes − 1 − index), and the bytes of a halfword or word element are reversed on the way between memory and the register. Taken together, these two rules make little-endian placement the exact reversal of the whole 16-byte big-endian mapping. Address generation, cache access, exceptions and the register file are handled elsewhere.

Top module: `vec_elem_steer`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. `vreg_out` and `mem_wdata` only change on the edge that captures a request and hold their values between requests. After reset every output is zero.
- R2: `req_size` encodes 0 = byte, 1 = halfword, 2 = word and 3 = reserved. Address bits below the element size are ignored, so the access is aligned down to the element size.
- R3: In a big-endian load, memory byte k of the element (k = 0 at the lowest address) lands in register byte eb+k. Here eb is the aligned byte offset, and register byte 0 is bits [127:120].
- R4: In a little-endian load, the lane index i = offset >> log2(size) is replaced by (16/size − 1 − i). This applies to byte elements too, which are otherwise written unchanged.
- R5: In a little-endian load of a halfword or word, the element bytes are reversed, so memory byte k lands in register byte 15 − eb − k.
- R6: A load leaves every register byte outside the selected element unchanged in `vreg_out`.
- R7: Memory byte lane j is `mem_rdata`/`mem_wdata` bits [31−8j : 24−8j] and holds the byte at address (EA & ~3) + j. A big-endian store writes register byte eb+k to lane (eb mod 4)+k.
- R8: A little-endian store writes register byte 15 − eb − k to lane (eb mod 4)+k. This combines lane mirroring with byte reversal.
- R9: On a store, `mem_be[j]` is set exactly for the lanes the element occupies, and unused write lanes are zero. `mem_be` is zero after a load, after an idle cycle and after a reserved-size request, and `mem_wdata` is zero after a load.
- R10: A store returns `vreg_out` equal to the `vreg_in` it was given.
- R11: A reserved-size request changes nothing: `vreg_out` equals `vreg_in`, and `mem_be` and `mem_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_le | input | 1 | 1 = little-endian mode |
| req_size | input | 2 | Element size code |
| req_addr | input | 4 | Low effective-address bits |
| vreg_in | input | 128 | Current vector register value |
| mem_rdata | input | 32 | Memory read word |
| rsp_valid | output | 1 | Result valid |
| vreg_out | output | 128 | Updated register value |
| mem_wdata | output | 32 | Memory write word |
| mem_be | output | 4 | Byte-lane write enables |

## Verification
A wrong lane decode shows up as a displaced or mirrored element in `vreg_out`, or as a wrong set of bits in `mem_be`. A wrong reverse control swaps bytes inside the element. A bad merge select corrupts bytes next to the element. All of these appear on the response cycle right after the request, because there is no state that carries across requests other than the held outputs. The sweep therefore covers every offset, size, direction and endian combination with fresh data. It also checks the idle cycle that follows each request, so that a stuck enable or an output that fails to hold is caught one cycle later.

// File: rtl/vs_pkg.sv
package vs_pkg;
   typedef enum logic [1:0] {
      VS_SZ_BYTE = 2'd0,
      VS_SZ_HALF = 2'd1,
      VS_SZ_WORD = 2'd2,
      VS_SZ_RSV  = 2'd3
   } vs_size_e;
endpackage

// File: rtl/vs_lane_decode.sv
module vs_lane_decode
   import vs_pkg::*;
#(
   parameter int VBYTES = 16,
   parameter int MBYTES = 4,
   localparam int AW = $clog2(VBYTES),
   localparam int MW = $clog2(MBYTES)
) (
   input  logic [AW-1:0] addr_i,
   input  vs_size_e      size_i,
   input  logic          le_i,
   output logic          act_o,
   output logic [AW:0]   nbytes_o,
   output logic [AW-1:0] rstart_o,
   output logic [MW-1:0] mofs_o
);
   int lg;
   int idx;
   int nel;
   int li;

   always_comb begin
      act_o = (size_i != VS_SZ_RSV);
      lg    = act_o ? int'(size_i) : 0;
      idx   = int'(addr_i) >> lg;
      nel   = VBYTES >> lg;
      // mirrored lane in little-endian mode
      li    = le_i ? (nel - 1 - idx) : idx;
      nbytes_o = (AW+1)'(act_o ? (1 << lg) : 0);
      rstart_o = AW'(li << lg);
      mofs_o   = MW'((idx << lg) % MBYTES);
   end
endmodule

// File: rtl/vs_load_merge.sv
module vs_load_merge #(
   parameter int VBYTES = 16,
   parameter int MBYTES = 4,
   localparam int AW = $clog2(VBYTES),
   localparam int MW = $clog2(MBYTES)
) (
   input  logic                  ld_i,
   input  logic                  rev_i,
   input  logic [AW:0]           nbytes_i,
   input  logic [AW-1:0]         rstart_i,
   input  logic [MW-1:0]         mofs_i,
   input  logic [8*VBYTES-1:0]   vreg_i,
   input  logic [8*MBYTES-1:0]   mdata_i,
   output logic [8*VBYTES-1:0]   vreg_o
);
   logic [7:0] mbyte [MBYTES];

   for (genvar j = 0; j < MBYTES; j++) begin : g_mb
      assign mbyte[j] = mdata_i[8*MBYTES-1-8*j -: 8];
   end

   for (genvar r = 0; r < VBYTES; r++) begin : g_rb
      int          off;
      int          k;
      logic        hit;
      logic [MW-1:0] lane;
      logic [7:0]  nb;

      always_comb begin
         off  = r - int'(rstart_i);
         hit  = ld_i && (off >= 0) && (off < int'(nbytes_i));
         k    = rev_i ? (int'(nbytes_i) - 1 - off) : off;
         lane = MW'(int'(mofs_i) + k);
         nb   = hit ? mbyte[lane] : vreg_i[8*VBYTES-1-8*r -: 8];
      end

      assign vreg_o[8*VBYTES-1-8*r -: 8] = nb;
   end
endmodule

// File: rtl/vs_store_pack.sv
module vs_store_pack #(
   parameter int VBYTES = 16,
   parameter int MBYTES = 4,
   localparam int AW = $clog2(VBYTES),
   localparam int MW = $clog2(MBYTES)
) (
   input  logic                  st_i,
   input  logic                  rev_i,
   input  logic [AW:0]           nbytes_i,
   input  logic [AW-1:0]         rstart_i,
   input  logic [MW-1:0]         mofs_i,
   input  logic [8*VBYTES-1:0]   vreg_i,
   output logic [8*MBYTES-1:0]   wdata_o,
   output logic [MBYTES-1:0]     be_o
);
   logic [7:0] vbyte [VBYTES];

   for (genvar r = 0; r < VBYTES; r++) begin : g_vb
      assign vbyte[r] = vreg_i[8*VBYTES-1-8*r -: 8];
   end

   for (genvar j = 0; j < MBYTES; j++) begin : g_lane
      int            off;
      int            rb;
      logic          hit;
      logic [AW-1:0] ridx;
      logic [7:0]    wb;

      always_comb begin
         off  = j - int'(mofs_i);
         hit  = st_i && (off >= 0) && (off < int'(nbytes_i));
         rb   = rev_i ? (int'(rstart_i) + int'(nbytes_i) - 1 - off)
                      : (int'(rstart_i) + off);
         ridx = AW'(rb);
         wb   = hit ? vbyte[ridx] : 8'h00;
      end

      assign wdata_o[8*MBYTES-1-8*j -: 8] = wb;
      assign be_o[j] = hit;
   end
endmodule

// File: rtl/vec_elem_steer.sv
module vec_elem_steer
   import vs_pkg::*;
#(
   parameter int VBYTES = 16,
   parameter int MBYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_store,
   input  logic                 req_le,
   input  logic [1:0]           req_size,
   input  logic [$clog2(VBYTES)-1:0] req_addr,
   input  logic [8*VBYTES-1:0]  vreg_in,
   input  logic [8*MBYTES-1:0]  mem_rdata,
   output logic                 rsp_valid,
   output logic [8*VBYTES-1:0]  vreg_out,
   output logic [8*MBYTES-1:0]  mem_wdata,
   output logic [MBYTES-1:0]    mem_be
);
   localparam int AW = $clog2(VBYTES);
   localparam int MW = $clog2(MBYTES);

   if ((VBYTES & (VBYTES - 1)) != 0 || (MBYTES & (MBYTES - 1)) != 0 ||
       MBYTES < 4 || VBYTES < 2 * MBYTES) begin : g_bad_cfg
      $error("vec_elem_steer: VBYTES and MBYTES must be powers of two, MBYTES >= 4, VBYTES >= 2*MBYTES");
   end

   logic                act;
   logic [AW:0]         nbytes;
   logic [AW-1:0]       rstart;
   logic [MW-1:0]       mofs;
   logic                do_ld;
   logic                do_st;
   logic [8*VBYTES-1:0] vreg_c;
   logic [8*MBYTES-1:0] wdata_c;
   logic [MBYTES-1:0]   be_c;

   vs_lane_decode #(.VBYTES(VBYTES), .MBYTES(MBYTES)) u_dec (
      .addr_i   (req_addr),
      .size_i   (vs_size_e'(req_size)),
      .le_i     (req_le),
      .act_o    (act),
      .nbytes_o (nbytes),
      .rstart_o (rstart),
      .mofs_o   (mofs)
   );

   assign do_ld = req_valid && !req_store && act;
   assign do_st = req_valid &&  req_store && act;

   vs_load_merge #(.VBYTES(VBYTES), .MBYTES(MBYTES)) u_ld (
      .ld_i     (do_ld),
      .rev_i    (req_le),
      .nbytes_i (nbytes),
      .rstart_i (rstart),
      .mofs_i   (mofs),
      .vreg_i   (vreg_in),
      .mdata_i  (mem_rdata),
      .vreg_o   (vreg_c)
   );

   vs_store_pack #(.VBYTES(VBYTES), .MBYTES(MBYTES)) u_st (
      .st_i     (do_st),
      .rev_i    (req_le),
      .nbytes_i (nbytes),
      .rstart_i (rstart),
      .mofs_i   (mofs),
      .vreg_i   (vreg_in),
      .wdata_o  (wdata_c),
      .be_o     (be_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         vreg_out  <= '0;
         mem_wdata <= '0;
         mem_be    <= '0;
      end else begin
         rsp_valid <= req_valid;
         mem_be    <= req_valid ? be_c : '0;
         if (req_valid) begin
            vreg_out  <= vreg_c;
            mem_wdata <= wdata_c;
         end
      end
   end
endmodule

// File: rtl/vs_checker.sv
module vs_checker #(
   parameter int VBYTES = 16,
   parameter int MBYTES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_store,
   input logic                 req_le,
   input logic [1:0]           req_size,
   input logic [$clog2(VBYTES)-1:0] req_addr,
   input logic [8*VBYTES-1:0]  vreg_in,
   input logic [8*MBYTES-1:0]  mem_rdata,
   input logic                 rsp_valid,
   input logic [8*VBYTES-1:0]  vreg_out,
   input logic [8*MBYTES-1:0]  mem_wdata,
   input logic [MBYTES-1:0]    mem_be
);
   // R1
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R1
   hold_vreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(vreg_out));
   // R9
   idle_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> mem_be == '0);
   // R9
   load_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store) |=> mem_be == '0);
   // R9
   be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && req_size != 2'd3)
      |=> $countones(mem_be) == (1 << $past(req_size)));
   // R10
   store_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store) |=> vreg_out == $past(vreg_in));
   // R11
   rsv_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd3)
      |=> (vreg_out == $past(vreg_in) && mem_be == '0 && mem_wdata == '0));
endmodule

bind vec_elem_steer vs_checker #(.VBYTES(VBYTES), .MBYTES(MBYTES)) u_vs_chk (.*);

// File: tb/test_vec_elem_steer.sv
module test_vec_elem_steer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_store = 1'b0;
   logic         req_le = 1'b0;
   logic [1:0]   req_size = 2'd0;
   logic [3:0]   req_addr = 4'd0;
   logic [127:0] vreg_in = '0;
   logic [31:0]  mem_rdata = '0;
   logic         rsp_valid;
   logic [127:0] vreg_out;
   logic [31:0]  mem_wdata;
   logic [3:0]   mem_be;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vec_elem_steer i_vec_elem_steer (
      .clk, .rst_n, .req_valid, .req_store, .req_le, .req_size, .req_addr,
      .vreg_in, .mem_rdata, .rsp_valid, .vreg_out, .mem_wdata, .mem_be
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset rsp_valid", 128'(rsp_valid), 128'd0);
      chk("R1 reset vreg_out", vreg_out, 128'd0);
      chk("R1 reset mem_wdata", 128'(mem_wdata), 128'd0);
      chk("R1 reset mem_be", 128'(mem_be), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int st = 0; st < 2; st++) begin
         for (int le = 0; le < 2; le++) begin
            for (int sz = 0; sz < 4; sz++) begin
               for (int a = 0; a < 16; a++) begin
                  logic [127:0] ev;
                  logic [31:0]  ew;
                  logic [3:0]   eb;
                  logic [127:0] held;
                  int           n;
                  int           al;
                  string        tg;
                  ev = {$urandom(), $urandom(), $urandom(), $urandom()};
                  vreg_in   = ev;
                  mem_rdata = $urandom();
                  req_store = st[0];
                  req_le    = le[0];
                  req_size  = 2'(sz);
                  req_addr  = 4'(a);
                  req_valid = 1'b1;
                  ew = '0;
                  eb = '0;
                  n  = (sz == 3) ? 0 : (1 << sz);
                  al = (n == 0) ? a : (a / n) * n;
                  for (int k = 0; k < n; k++) begin
                     int rb;
                     int ml;
                     rb = le ? (15 - al - k) : (al + k);
                     ml = (al % 4) + k;
                     if (st == 0) ev[127 - 8*rb -: 8] = mem_rdata[31 - 8*ml -: 8];
                     else begin
                        ew[31 - 8*ml -: 8] = vreg_in[127 - 8*rb -: 8];
                        eb[ml] = 1'b1;
                     end
                  end
                  if (sz == 3) tg = "R11";
                  else if (st != 0) tg = le ? "R8" : "R7";
                  else if (le != 0) tg = (sz == 0) ? "R4" : "R4/R5";
                  else tg = "R3";
                  if (n > 1 && al != a) tg = {tg, "/R2"};
                  tg = $sformatf("%s st=%0d le=%0d sz=%0d a=%0d", tg, st, le, sz, a);
                  @(negedge clk);
                  req_valid = 1'b0;
                  chk({"R1 rsp_valid ", tg}, 128'(rsp_valid), 128'd1);
                  chk({(st != 0) ? "R10 vreg_out " : "R6 vreg_out ", tg}, vreg_out, ev);
                  chk({"R9 mem_wdata ", tg}, 128'(mem_wdata), 128'(ew));
                  chk({"R9 mem_be ", tg}, 128'(mem_be), 128'(eb));
                  held = vreg_out;
                  vreg_in = ~vreg_in;
                  @(negedge clk);
                  chk({"R1 idle rsp_valid ", tg}, 128'(rsp_valid), 128'd0);
                  chk({"R1 idle vreg_out hold ", tg}, vreg_out, held);
                  chk({"R9 idle mem_be ", tg}, 128'(mem_be), 128'd0);
               end
            end
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule